// File: doc/BRIEF.md
# UART Transmit Status Flags

This block keeps the two transmit-side status flags of a serial port's register interface. The first flag says the transmit buffer has drained to a programmable watermark. The second says the transmitter has gone completely quiet. Both flags are registered and sticky. Software clears a flag with two steps: a status read taken while the flag is set arms the clear, and a later qualifying action carries it out. If the condition that raised a flag is still present once the clear has happened, the flag rises again on the following cycle.

The buffer occupancy comes in as a count. That count leaves out the character the shifter is currently sending. The shifter's busy state arrives on its own input and covers data, preamble and break characters. The block packs both flags, together with six receive-side flags supplied from elsewhere, into one status byte. It also drives a level-sensitive interrupt/DMA request, formed combinationally from the registered flags and their enables.

Top module: `uart_tx_status`

## Requirements
- R1: In the first cycle after synchronous reset, `txe_flag` and `txc_flag` are both 1. Status bits 7 and 6 are therefore 1.
- R2: `status` is laid out as follows. Bit 7 is `txe_flag`. Bit 6 is `txc_flag`. Bits 5..0 carry `rx_flags[5:0]` unchanged, in this order: receive-full (bit 5), idle (4), overrun (3), noise (2), framing error (1), parity error (0).
- R3: `txe_flag` is 1 in the cycle after any cycle in which `fill_level <= watermark` and no clear takes effect. Once set, it stays set until a clear takes effect, whatever the fill level does. A fill level above the watermark never sets it.
- R4: `txe_flag` is 0 in the cycle after a `data_wr` when either of these holds: a `stat_rd` was seen while the flag was set, in an earlier cycle or in the same cycle; or the clear is still armed. A `data_wr` with no armed read has no effect on the flag.
- R5: After a clear, the flag is low for exactly one cycle. If the fill level in that low cycle is at or below the watermark, the flag sets again in the next cycle and so raises a new request. This covers the case where a refill was too short to lift the buffer above the watermark.
- R6: Each flag is armed separately. A read arms only the flags that are set at that moment. The armed state persists over idle cycles and is used up by the clear it enables. It is cancelled when its flag drops for any other reason, and an action that then arrives without a new read has no effect.
- R7: `txc_flag` is 1 in the cycle after any cycle with `fill_level == 0`, `shifter_busy == 0` and no clear taking effect. Otherwise it keeps its value, unless R8 or R9 applies.
- R8: `txc_flag` is 0 in the cycle after any cycle with `shifter_busy == 1`.
- R9: With the `txc_flag` clear armed, any one of three actions makes `txc_flag` 0 in the next cycle: a `data_wr`; a `brk_req` strobe; or `tx_en` rising from 0 in one cycle to 1 in the next, which queues a preamble. A falling `tx_en` is not a qualifying action.
- R10: `irq` equals (`txe_flag` AND `txe_ie`) OR (`txc_flag` AND `txc_ie`), with no added cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_level | input | FILL_W | Words waiting in the transmit buffer, not counting the one being shifted |
| watermark | input | FILL_W | Programmed watermark threshold |
| shifter_busy | input | 1 | Data, preamble or break character being sent |
| tx_en | input | 1 | Transmitter enable level |
| stat_rd | input | 1 | Status register read strobe |
| data_wr | input | 1 | Data register write strobe |
| brk_req | input | 1 | Break bit write strobe |
| rx_flags | input | 6 | Receive-side flags placed in status bits 5..0 |
| txe_ie | input | 1 | Request enable for the watermark flag |
| txc_ie | input | 1 | Request enable for the transmit-complete flag |
| txe_flag | output | 1 | Transmit buffer at or below watermark (sticky) |
| txc_flag | output | 1 | Transmitter fully idle |
| irq | output | 1 | Interrupt/DMA request, level |
| status | output | 8 | Packed status byte |

## Verification
The status read that arms a clear and the data write that performs it can land in the same cycle. The bench drives them together on a set flag and expects the flag low on the next edge. A clear action can also coincide with the flag's own cause still being present. Here the bench completes a refill that leaves the buffer at the watermark and expects one low cycle followed by a new rise. A further case drops the transmit-complete flag through `shifter_busy` between the read and the break strobe, and the bench judges the break to be ignored. A behavioural model that runs alongside checks flags, request and status byte every cycle, including through a stretch of random strobes and occupancies.

// File: rtl/uart_txstat_pkg.sv
package uart_txstat_pkg;

    localparam int STAT_W   = 8;
    localparam int RXF_W    = 6;
    localparam int NFLAG    = 2;
    localparam int FIDX_TXE = 0;
    localparam int FIDX_TXC = 1;

    // Packed status byte, most significant field first
    typedef struct packed {
        logic             txe;
        logic             txc;
        logic [RXF_W-1:0] rx;
    } stat_byte_t;

    // Per-flag control bundle presented to a flag cell each cycle
    typedef struct packed {
        logic rd;    // status register read strobe
        logic act;   // a qualifying clear action
        logic set;   // cause of the flag is present
        logic drop;  // hardware condition forcing the flag low
    } flag_ctl_t;

    // True when a clear action is allowed to take effect
    function automatic logic clear_allowed(input logic rd, input logic flag, input logic armed);
        return flag & (armed | rd);
    endfunction

endpackage

// File: rtl/txs_cause.sv
module txs_cause
    import uart_txstat_pkg::*;
#(
    parameter int FILL_W = 5
) (
    input  logic                    clk,
    input  logic [FILL_W-1:0]       fill_level,
    input  logic [FILL_W-1:0]       watermark,
    input  logic                    shifter_busy,
    input  logic                    tx_en,
    input  logic                    stat_rd,
    input  logic                    data_wr,
    input  logic                    brk_req,
    output flag_ctl_t [NFLAG-1:0]   ctl
);

    logic tx_en_q;
    logic en_rise;
    logic at_or_below;
    logic buf_empty;

    // Previous enable level; a 0 -> 1 step queues a preamble
    always_ff @(posedge clk) begin
        tx_en_q <= tx_en;
    end

    always_comb begin
        en_rise     = tx_en & ~tx_en_q;
        at_or_below = (fill_level <= watermark);
        buf_empty   = (fill_level == '0);

        ctl[FIDX_TXE].rd   = stat_rd;
        ctl[FIDX_TXE].act  = data_wr;
        ctl[FIDX_TXE].set  = at_or_below;
        ctl[FIDX_TXE].drop = 1'b0;

        ctl[FIDX_TXC].rd   = stat_rd;
        ctl[FIDX_TXC].act  = data_wr | en_rise | brk_req;
        ctl[FIDX_TXC].set  = buf_empty & ~shifter_busy;
        ctl[FIDX_TXC].drop = shifter_busy;
    end

endmodule

// File: rtl/txs_flag_cell.sv
module txs_flag_cell
    import uart_txstat_pkg::*;
#(
    parameter logic RST_VAL = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  flag_ctl_t ctl,
    output logic      flag
);

    logic armed;
    logic clr;
    logic flag_d;
    logic armed_d;

    always_comb begin
        clr     = ctl.act & clear_allowed(ctl.rd, flag, armed);
        flag_d  = (clr | ctl.drop) ? 1'b0 : (flag | ctl.set);
        // Arm survives only while the flag stays up into the next cycle
        armed_d = flag_d & (armed | (ctl.rd & flag));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= RST_VAL;
            armed <= 1'b0;
        end else begin
            flag  <= flag_d;
            armed <= armed_d;
        end
    end

endmodule

// File: rtl/txs_pack.sv
module txs_pack
    import uart_txstat_pkg::*;
(
    input  logic              txe,
    input  logic              txc,
    input  logic [RXF_W-1:0]  rx_flags,
    input  logic              txe_ie,
    input  logic              txc_ie,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    stat_byte_t sb;

    always_comb begin
        sb.txe = txe;
        sb.txc = txc;
        sb.rx  = rx_flags;
        status = sb;
        irq    = (txe & txe_ie) | (txc & txc_ie);
    end

endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status
    import uart_txstat_pkg::*;
#(
    parameter  int TXQ_DEPTH = 16,
    localparam int FILL_W    = $clog2(TXQ_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FILL_W-1:0] fill_level,
    input  logic [FILL_W-1:0] watermark,
    input  logic              shifter_busy,
    input  logic              tx_en,
    input  logic              stat_rd,
    input  logic              data_wr,
    input  logic              brk_req,
    input  logic [RXF_W-1:0]  rx_flags,
    input  logic              txe_ie,
    input  logic              txc_ie,
    output logic              txe_flag,
    output logic              txc_flag,
    output logic              irq,
    output logic [STAT_W-1:0] status
);

    flag_ctl_t [NFLAG-1:0] ctl;
    logic      [NFLAG-1:0] flags;

    txs_cause #(.FILL_W(FILL_W)) u_cause (
        .clk          (clk),
        .fill_level   (fill_level),
        .watermark    (watermark),
        .shifter_busy (shifter_busy),
        .tx_en        (tx_en),
        .stat_rd      (stat_rd),
        .data_wr      (data_wr),
        .brk_req      (brk_req),
        .ctl          (ctl)
    );

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        txs_flag_cell #(.RST_VAL(1'b1)) u_cell (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ctl[g]),
            .flag (flags[g])
        );
    end

    assign txe_flag = flags[FIDX_TXE];
    assign txc_flag = flags[FIDX_TXC];

    txs_pack u_pack (
        .txe      (txe_flag),
        .txc      (txc_flag),
        .rx_flags (rx_flags),
        .txe_ie   (txe_ie),
        .txc_ie   (txc_ie),
        .status   (status),
        .irq      (irq)
    );

endmodule

// File: rtl/txs_chk.sv
module txs_chk
    import uart_txstat_pkg::*;
#(
    parameter int FILL_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [FILL_W-1:0] fill_level,
    input logic [FILL_W-1:0] watermark,
    input logic              shifter_busy,
    input logic              tx_en,
    input logic              stat_rd,
    input logic              data_wr,
    input logic              brk_req,
    input logic [RXF_W-1:0]  rx_flags,
    input logic              txe_ie,
    input logic              txc_ie,
    input logic              txe_flag,
    input logic              txc_flag,
    input logic              irq,
    input logic [STAT_W-1:0] status
);

    // R1
    reset_ones_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (txe_flag && txc_flag));

    // R2
    status_layout_chk: assert property (@(posedge clk) disable iff (rst)
        status == {txe_flag, txc_flag, rx_flags});

    // R3
    txe_set_chk: assert property (@(posedge clk) disable iff (rst)
        ((fill_level <= watermark) && !data_wr) |=> txe_flag);

    // R3
    txe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (txe_flag && !data_wr) |=> txe_flag);

    // R4
    txe_same_cycle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (txe_flag && stat_rd && data_wr) |=> !txe_flag);

    // R7
    txc_set_chk: assert property (@(posedge clk) disable iff (rst)
        ((fill_level == '0) && !shifter_busy && !data_wr && !brk_req && $stable(tx_en))
        |=> txc_flag);

    // R8
    txc_busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        shifter_busy |=> !txc_flag);

    // R10
    irq_mix_chk: assert property (@(posedge clk) disable iff (rst)
        irq == ((txe_flag && txe_ie) || (txc_flag && txc_ie)));

endmodule

bind uart_tx_status txs_chk #(.FILL_W(FILL_W)) u_txs_chk (
    .clk          (clk),
    .rst          (rst),
    .fill_level   (fill_level),
    .watermark    (watermark),
    .shifter_busy (shifter_busy),
    .tx_en        (tx_en),
    .stat_rd      (stat_rd),
    .data_wr      (data_wr),
    .brk_req      (brk_req),
    .rx_flags     (rx_flags),
    .txe_ie       (txe_ie),
    .txc_ie       (txc_ie),
    .txe_flag     (txe_flag),
    .txc_flag     (txc_flag),
    .irq          (irq),
    .status       (status)
);

// File: tb/test_uart_tx_status.sv
`timescale 1ns/1ps
module test_uart_tx_status;

    localparam int DEPTH = 16;
    localparam int FW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [FW-1:0] fill_level = '0;
    logic [FW-1:0] watermark  = FW'(4);
    logic          shifter_busy = 1'b0;
    logic          tx_en   = 1'b0;
    logic          stat_rd = 1'b0;
    logic          data_wr = 1'b0;
    logic          brk_req = 1'b0;
    logic [5:0]    rx_flags = '0;
    logic          txe_ie = 1'b0;
    logic          txc_ie = 1'b0;
    logic          txe_flag, txc_flag, irq;
    logic [7:0]    status;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    // reference model state
    bit m_e, m_c, m_ae, m_ac, m_pen;

    always #2.5 clk = ~clk;  // 200 MHz

    uart_tx_status #(.TXQ_DEPTH(DEPTH)) i_uart_tx_status (
        .clk(clk), .rst(rst), .fill_level(fill_level), .watermark(watermark),
        .shifter_busy(shifter_busy), .tx_en(tx_en), .stat_rd(stat_rd),
        .data_wr(data_wr), .brk_req(brk_req), .rx_flags(rx_flags),
        .txe_ie(txe_ie), .txc_ie(txc_ie), .txe_flag(txe_flag),
        .txc_flag(txc_flag), .irq(irq), .status(status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model, updated at every rising edge
    always @(posedge clk) begin
        bit rise, kill_e, kill_c, ne, nc;
        if (rst) begin
            m_e = 1; m_c = 1; m_ae = 0; m_ac = 0;
        end else begin
            rise   = tx_en && !m_pen;
            kill_e = data_wr && m_e && (m_ae || stat_rd);
            kill_c = (data_wr || rise || brk_req) && m_c && (m_ac || stat_rd);
            if (kill_e) ne = 0;
            else ne = m_e || (int'(fill_level) <= int'(watermark));
            if (kill_c || shifter_busy) nc = 0;
            else nc = m_c || (fill_level == 0);
            m_ae = ne && (m_ae || (stat_rd && m_e));
            m_ac = nc && (m_ac || (stat_rd && m_c));
            m_e  = ne;
            m_c  = nc;
        end
        m_pen = tx_en;
    end

    // Compare every cycle, away from the edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(txe_flag == m_e, "R3 R4 R5 model txe_flag", txe_flag, m_e);
            chk(txc_flag == m_c, "R7 R8 R9 model txc_flag", txc_flag, m_c);
            chk(irq == ((m_e && txe_ie) || (m_c && txc_ie)), "R10 model irq", irq,
                (m_e && txe_ie) || (m_c && txc_ie));
            chk(status == {m_e, m_c, rx_flags}, "R2 model status", status,
                {m_e, m_c, rx_flags});
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        stat_rd = 0; data_wr = 0; brk_req = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk(txe_flag == 1, "R1 txe_flag after reset", txe_flag, 1);
        chk(txc_flag == 1, "R1 txc_flag after reset", txc_flag, 1);
        chk(status == 8'hC0, "R1 status after reset", status, 8'hC0);

        // R2 layout
        rx_flags = 6'b101010; #1;
        chk(status == 8'hEA, "R2 status packing", status, 8'hEA);

        // R4 write without armed read is ignored
        data_wr = 1; tick();
        chk(txe_flag == 1, "R4 unarmed write ignored", txe_flag, 1);
        chk(txc_flag == 1, "R9 unarmed write ignored txc", txc_flag, 1);

        // R5 clear then reassert with buffer still low
        stat_rd = 1; tick();
        data_wr = 1; tick();
        chk(txe_flag == 0, "R4 txe cleared by read then write", txe_flag, 0);
        chk(txc_flag == 0, "R9 txc cleared by data write", txc_flag, 0);
        tick();
        chk(txe_flag == 1, "R5 txe reasserts", txe_flag, 1);

        // R3 above threshold does not set, equal does
        fill_level = 6; stat_rd = 1; tick();
        data_wr = 1; tick();
        tick(); tick();
        chk(txe_flag == 0, "R3 no set above watermark", txe_flag, 0);
        fill_level = 4; tick(); tick();
        chk(txe_flag == 1, "R3 set at watermark", txe_flag, 1);

        // R5 incomplete refill leaves buffer at or below threshold
        fill_level = 2; stat_rd = 1; tick();
        fill_level = 3; data_wr = 1; tick();
        chk(txe_flag == 0, "R5 low after refill write", txe_flag, 0);
        tick();
        chk(txe_flag == 1, "R5 reasserts after short refill", txe_flag, 1);

        // R6 R7 R8 arming per flag and cancellation
        fill_level = 0; tick(); tick();
        chk(txc_flag == 1, "R7 txc sets when idle and empty", txc_flag, 1);
        stat_rd = 1; tick();
        shifter_busy = 1; tick();
        chk(txc_flag == 0, "R8 txc drops while busy", txc_flag, 0);
        shifter_busy = 0; tick();
        chk(txc_flag == 1, "R7 txc returns when idle", txc_flag, 1);
        brk_req = 1; tick();
        chk(txc_flag == 1, "R6 cancelled arm ignores break", txc_flag, 1);
        data_wr = 1; tick();
        chk(txe_flag == 0, "R6 txe arm persisted", txe_flag, 0);
        chk(txc_flag == 1, "R6 txc not armed", txc_flag, 1);
        tick();

        // R9 break
        stat_rd = 1; tick();
        brk_req = 1; tick();
        chk(txc_flag == 0, "R9 break clears txc", txc_flag, 0);
        tick();

        // R9 preamble via enable rise; fall has no effect
        stat_rd = 1; tick();
        tx_en = 1; tick();
        chk(txc_flag == 0, "R9 enable rise clears txc", txc_flag, 0);
        tick();
        stat_rd = 1; tick();
        tx_en = 0; tick();
        chk(txc_flag == 1, "R9 enable fall ignored", txc_flag, 1);
        tx_en = 1; tick();
        chk(txc_flag == 0, "R9 armed rise after fall clears", txc_flag, 0);
        tick();

        // R10 request
        chk(irq == 0, "R10 irq masked", irq, 0);
        txe_ie = 1; #1;
        chk(irq == 1, "R10 irq from txe", irq, 1);
        txc_ie = 1; fill_level = 6; stat_rd = 1; tick();
        data_wr = 1; tick();
        chk(irq == 0, "R10 irq low with both flags clear", irq, 0);
        fill_level = 0; tick(); tick();
        chk(irq == 1, "R10 irq high again", irq, 1);

        // R4 read and write in the same cycle
        fill_level = 6; stat_rd = 1; data_wr = 1; tick();
        chk(txe_flag == 0, "R4 same-cycle read and write", txe_flag, 0);

        // random stretch compared against the model
        for (int i = 0; i < 600; i++) begin
            fill_level   = FW'($urandom_range(0, 8));
            watermark    = FW'($urandom_range(0, 6));
            shifter_busy = ($urandom_range(0, 3) == 0);
            tx_en        = ($urandom_range(0, 4) != 0);
            stat_rd      = ($urandom_range(0, 2) == 0);
            data_wr      = ($urandom_range(0, 2) == 0);
            brk_req      = ($urandom_range(0, 6) == 0);
            rx_flags     = 6'($urandom);
            txe_ie       = $urandom_range(0, 1) == 1;
            txc_ie       = $urandom_range(0, 1) == 1;
            tick();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R1 actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule